// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block decides, in a single combinational pass, whether two adjacent decoded instructions of an in-order integer pipeline may issue in the same cycle. The older instruction is offered to the primary slot (U) and the younger one to the secondary slot (V). Each slot arrives as a descriptor built by the decoder. It carries a fast-path flag, hints saying whether the instruction may lead or trail a pair, register read and write bitmasks, and flags for a load, a branch, a prefix and a displacement combined with an immediate. The U slot also gives its length in bytes and whether it is an absolute-offset store of the accumulator.

The checker returns a grant and a 3-bit reason code. Checks are ranked, and the first one that fails is the code that is reported. Asymmetric pairing classes are built from the lead and trail hints together with the branch and prefix flags. The stack-pointer bit of the masks never counts as a hazard. A load may not fill V. An optional erratum mode refuses to pair an accumulator moffs store with a V instruction that touches the accumulator. When the fetch pair straddles a cache-line split, only a 1-byte U instruction may still pair.

Top module: `uv_pair_check`

## Requirements
- R1: If either `u_valid` or `v_valid` is 0, `pair_ok` is 0 and `reason` is 1 (no candidate).
- R2: The U instruction fails the class check (reason 2) unless it is simple, has `u_lead_ok` set, and is not a branch. Branches are V-only. Not-simple ops never pair.
- R3: The V instruction fails the class check (reason 2) unless it is simple, has `v_trail_ok` set, and is not prefixed. Carry-consuming ops and shifts arrive with `v_trail_ok`=0 and so stay U-only. Prefixed ops stay U-only.
- R4: If any register bit set in `v_rd` or `v_wr` is also set in `u_wr`, the hazard check fails (reason 3).
- R5: Bit `SP_IDX` (default 4, the stack pointer) of the masks is ignored by the hazard check, so push/push pairs are granted.
- R6: If `u_dispimm` or `v_dispimm` is 1, the displacement-plus-immediate check fails (reason 4).
- R7: If `v_load` is 1, the load check fails (reason 5). A load in U (`u_load`) does not by itself refuse a pair.
- R8: With `erratum_en`=1, if `u_acc_store` is set and bit `ACC_IDX` (default 0) of `v_rd` or `v_wr` is set, the erratum check fails (reason 6). With `erratum_en`=0 the same pair is granted.
- R9: If `line_split` is 1 and `u_len` is not 1, the split check fails (reason 7). A 1-byte U instruction is exempt.
- R10: The priority is no-candidate, class, hazard, disp+imm, load, erratum, split. The first failing check sets `reason`. `pair_ok` is 1 exactly when `reason` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| erratum_en | input | 1 | Enables the false accumulator dependency model |
| line_split | input | 1 | The instruction pair straddles a fetch-line split |
| u_valid | input | 1 | U slot holds an instruction |
| u_simple | input | 1 | U instruction is on the single-cycle fast path |
| u_lead_ok | input | 1 | U instruction may lead a pair |
| u_rd | input | NREG | U register read mask |
| u_wr | input | NREG | U register write mask |
| u_load | input | 1 | U instruction is a load |
| u_branch | input | 1 | U instruction is a branch |
| u_dispimm | input | 1 | U has both displacement and immediate |
| u_acc_store | input | 1 | U is an absolute-offset store of the accumulator |
| u_len | input | LEN_W | U instruction length in bytes |
| v_valid | input | 1 | V slot holds an instruction |
| v_simple | input | 1 | V instruction is on the fast path |
| v_trail_ok | input | 1 | V instruction may trail a pair |
| v_rd | input | NREG | V register read mask |
| v_wr | input | NREG | V register write mask |
| v_load | input | 1 | V instruction is a load |
| v_prefix | input | 1 | V instruction carries a prefix |
| v_dispimm | input | 1 | V has both displacement and immediate |
| pair_ok | output | 1 | Grant to issue both slots together |
| reason | output | 3 | 0 granted, 1 none, 2 class, 3 hazard, 4 disp+imm, 5 load, 6 erratum, 7 split |

## Verification
The hardest codes to reach are the late ones, erratum and split. Each needs every earlier check to pass at once, which uniform random descriptors almost never do. The random generator therefore starts each vector from a clean pair with disjoint masks. It then breaks each check with its own low probability, so every code appears often. Directed vectors cover the stack-pointer exemption, the 1-byte split exemption, and the same moffs pair sent with the erratum mode on and off.

// File: rtl/uv_pair_check.sv
module uv_pair_check #(
  parameter int NREG    = 8,
  parameter int SP_IDX  = 4,
  parameter int ACC_IDX = 0,
  parameter int LEN_W   = 4
) (
  input  logic             erratum_en,
  input  logic             line_split,
  input  logic             u_valid,
  input  logic             u_simple,
  input  logic             u_lead_ok,
  input  logic [NREG-1:0]  u_rd,
  input  logic [NREG-1:0]  u_wr,
  input  logic             u_load,
  input  logic             u_branch,
  input  logic             u_dispimm,
  input  logic             u_acc_store,
  input  logic [LEN_W-1:0] u_len,
  input  logic             v_valid,
  input  logic             v_simple,
  input  logic             v_trail_ok,
  input  logic [NREG-1:0]  v_rd,
  input  logic [NREG-1:0]  v_wr,
  input  logic             v_load,
  input  logic             v_prefix,
  input  logic             v_dispimm,
  output logic             pair_ok,
  output logic [2:0]       reason
);

  localparam logic [2:0] RS_OK   = 3'd0;
  localparam logic [2:0] RS_NONE = 3'd1;
  localparam logic [2:0] RS_CLS  = 3'd2;
  localparam logic [2:0] RS_HAZ  = 3'd3;
  localparam logic [2:0] RS_DI   = 3'd4;
  localparam logic [2:0] RS_LD   = 3'd5;
  localparam logic [2:0] RS_ERR  = 3'd6;
  localparam logic [2:0] RS_SPL  = 3'd7;

  localparam logic [NREG-1:0] SP_MASK = ~(NREG'(1) << SP_IDX);
  localparam logic [LEN_W-1:0] ONE_BYTE = LEN_W'(1);

  logic [NREG-1:0] v_touch;
  logic            bad_none, bad_cls, bad_haz, bad_di, bad_ld, bad_err, bad_spl;

  assign v_touch  = (v_rd | v_wr) & SP_MASK;
  assign bad_none = !u_valid || !v_valid;
  assign bad_cls  = !u_simple || !u_lead_ok || u_branch ||
                    !v_simple || !v_trail_ok || v_prefix;
  assign bad_haz  = |(v_touch & u_wr);
  assign bad_di   = u_dispimm || v_dispimm;
  assign bad_ld   = v_load;
  assign bad_err  = erratum_en && u_acc_store && (v_rd[ACC_IDX] || v_wr[ACC_IDX]);
  assign bad_spl  = line_split && (u_len != ONE_BYTE);

  always_comb begin
    if (bad_none)     reason = RS_NONE;
    else if (bad_cls) reason = RS_CLS;
    else if (bad_haz) reason = RS_HAZ;
    else if (bad_di)  reason = RS_DI;
    else if (bad_ld)  reason = RS_LD;
    else if (bad_err) reason = RS_ERR;
    else if (bad_spl) reason = RS_SPL;
    else              reason = RS_OK;
  end

  assign pair_ok = (reason == RS_OK);

  always_comb begin
    if (pair_ok) begin
      assert_valid_R1: assert (u_valid && v_valid);
      assert_branch_in_v_R2: assert (!u_branch && u_simple);
      assert_no_prefix_v_R3: assert (!v_prefix && v_trail_ok);
      assert_no_overlap_R4: assert ((((v_rd | v_wr) & u_wr) & SP_MASK) == '0);
      assert_no_dispimm_R6: assert (!u_dispimm && !v_dispimm);
      assert_no_v_load_R7: assert (!v_load);
      assert_split_len_R9: assert (!line_split || u_len == ONE_BYTE);
    end
    if (!u_valid || !v_valid) begin
      assert_none_code_R1: assert (reason == RS_NONE);
    end
    if (!erratum_en && u_valid && v_valid) begin
      assert_erratum_off_R8: assert (reason != RS_ERR);
    end
    assert_grant_code_R10: assert (pair_ok == (reason == RS_OK));
  end

endmodule

// File: tb/test_uv_pair_check.sv
module test_uv_pair_check;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int SP_IDX = 4;
  localparam int ACC_IDX = 0;
  localparam int LEN_W = 4;
  localparam int NRAND = 3000;

  logic clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic erratum_en, line_split;
  logic u_valid, u_simple, u_lead_ok, u_load, u_branch, u_dispimm, u_acc_store;
  logic [NREG-1:0] u_rd, u_wr, v_rd, v_wr;
  logic [LEN_W-1:0] u_len;
  logic v_valid, v_simple, v_trail_ok, v_load, v_prefix, v_dispimm;
  logic pair_ok;
  logic [2:0] reason;

  int vectors = 0;
  int misses = 0;
  bit done = 0;

  uv_pair_check #(.NREG(NREG), .SP_IDX(SP_IDX), .ACC_IDX(ACC_IDX), .LEN_W(LEN_W)) i_uv_pair_check (
    .erratum_en(erratum_en), .line_split(line_split),
    .u_valid(u_valid), .u_simple(u_simple), .u_lead_ok(u_lead_ok),
    .u_rd(u_rd), .u_wr(u_wr), .u_load(u_load), .u_branch(u_branch),
    .u_dispimm(u_dispimm), .u_acc_store(u_acc_store), .u_len(u_len),
    .v_valid(v_valid), .v_simple(v_simple), .v_trail_ok(v_trail_ok),
    .v_rd(v_rd), .v_wr(v_wr), .v_load(v_load), .v_prefix(v_prefix),
    .v_dispimm(v_dispimm), .pair_ok(pair_ok), .reason(reason)
  );

  function automatic logic [2:0] expect_code();
    logic [NREG-1:0] touch;
    touch = v_rd | v_wr;
    touch[SP_IDX] = 1'b0;
    if (!u_valid || !v_valid) return 3'd1;
    if (!u_simple || !u_lead_ok || u_branch || !v_simple || !v_trail_ok || v_prefix) return 3'd2;
    if ((touch & u_wr) != 0) return 3'd3;
    if (u_dispimm || v_dispimm) return 3'd4;
    if (v_load) return 3'd5;
    if (erratum_en && u_acc_store && (v_rd[ACC_IDX] || v_wr[ACC_IDX])) return 3'd6;
    if (line_split && u_len != 1) return 3'd7;
    return 3'd0;
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R2/R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic clean_pair();
    erratum_en = 0; line_split = 0;
    u_valid = 1; u_simple = 1; u_lead_ok = 1; u_load = 0; u_branch = 0;
    u_dispimm = 0; u_acc_store = 0; u_len = 4'd2;
    u_rd = 8'b0000_0010; u_wr = 8'b0000_0010;
    v_valid = 1; v_simple = 1; v_trail_ok = 1; v_load = 0; v_prefix = 0;
    v_dispimm = 0; v_rd = 8'b0000_1000; v_wr = 8'b0000_1000;
  endtask

  task automatic check(string tag);
    logic [2:0] exp_c;
    @(negedge clk);
    exp_c = expect_code();
    vectors++;
    if (reason !== exp_c || pair_ok !== (exp_c == 3'd0)) begin
      misses++;
      $display("FAIL %s: reason=%0d pair_ok=%0d expected reason=%0d pair_ok=%0d",
               tag, reason, pair_ok, exp_c, exp_c == 3'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clean_pair(); check("R10 clean pair granted");
    clean_pair(); u_valid = 0; check("R1 U empty");
    clean_pair(); v_valid = 0; u_branch = 1; check("R1 V empty outranks class");
    clean_pair(); u_branch = 1; check("R2 branch in U");
    clean_pair(); u_simple = 0; check("R2 slow-path U");
    clean_pair(); u_lead_ok = 0; check("R2 V-only op leading");
    clean_pair(); v_trail_ok = 0; check("R3 carry op trailing");
    clean_pair(); v_prefix = 1; check("R3 prefixed V");
    clean_pair(); v_rd = 8'b0000_0010; check("R4 RAW");
    clean_pair(); v_wr = 8'b0000_0010; v_rd = 0; check("R4 WAW");
    clean_pair(); u_rd = 8'b0000_1000; check("R4 U read of V dest is fine");
    clean_pair(); u_wr = 8'b0001_0000; v_rd = 8'b0001_0000; v_wr = 8'b0001_0000;
    check("R5 stack pointer exempt");
    clean_pair(); u_dispimm = 1; v_rd = 8'b0000_0010; check("R10 hazard outranks dispimm");
    clean_pair(); v_dispimm = 1; check("R6 V dispimm");
    clean_pair(); u_dispimm = 1; check("R6 U dispimm");
    clean_pair(); v_load = 1; check("R7 V load");
    clean_pair(); u_load = 1; check("R7 U load pairs");
    clean_pair(); erratum_en = 1; u_acc_store = 1; u_wr = 0; u_rd = 8'b0000_0001;
    v_rd = 8'b0000_0001; v_wr = 0; check("R8 erratum vetoes");
    erratum_en = 0; check("R8 erratum off pairs");
    clean_pair(); line_split = 1; check("R9 split veto");
    u_len = 4'd1; check("R9 one-byte exempt");
    clean_pair(); line_split = 1; v_load = 1; check("R10 load outranks split");

    for (int n = 0; n < NRAND; n++) begin
      logic [2:0] e;
      clean_pair();
      u_valid     = ($urandom % 20) != 0;
      v_valid     = ($urandom % 20) != 0;
      u_simple    = ($urandom % 25) != 0;
      u_lead_ok   = ($urandom % 25) != 0;
      u_branch    = ($urandom % 25) == 0;
      v_simple    = ($urandom % 25) != 0;
      v_trail_ok  = ($urandom % 25) != 0;
      v_prefix    = ($urandom % 25) == 0;
      u_wr        = NREG'($urandom) & NREG'($urandom);
      u_rd        = NREG'($urandom);
      v_rd        = NREG'($urandom) & ~u_wr;
      v_wr        = NREG'($urandom) & NREG'($urandom) & ~u_wr;
      if (($urandom % 6) == 0) v_rd = v_rd | u_wr;
      if (($urandom % 4) == 0) begin u_wr[SP_IDX] = 1; v_rd[SP_IDX] = 1; end
      u_dispimm   = ($urandom % 12) == 0;
      v_dispimm   = ($urandom % 12) == 0;
      u_load      = ($urandom % 3) == 0;
      v_load      = ($urandom % 10) == 0;
      erratum_en  = ($urandom % 2) == 0;
      u_acc_store = ($urandom % 3) == 0;
      if (u_acc_store) begin u_wr[ACC_IDX] = 0; v_rd[ACC_IDX] = ($urandom % 2) == 0; end
      line_split  = ($urandom % 4) == 0;
      u_len       = LEN_W'(1 + ($urandom % 6));
      e = expect_code();
      check(tag_of(e));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule